// File: doc/BRIEF.md
# Nonvolatile Memory Access Interlock

This block stands between a host and a small byte-wide nonvolatile array. The array also holds a 4-byte control page. While a refresh-enable bit is set, a background loop copies that page into shadow configuration registers, one byte per clock cycle. Before the host may read or write the array, it must clear refresh-enable. It must then confirm that the busy flag reads 0. When the access sequence is finished, it sets refresh-enable again so that the shadow registers track the array once more.

A host write is only latched when it arrives. Programming begins when the bus transaction's stop condition is signalled. From that point busy is high for a fixed number of clock cycles, set by a parameter. The data is committed to the array at the end of that window. If the supply-good input drops during programming, the write is abandoned, the target byte is flagged invalid, and busy clears. Any access that breaks the interlock is refused and sets a sticky error flag. The host clears that flag through the control register.

Top module: `nvm_access_guard`

## Requirements
- R1: After reset, refresh_en is 1, busy is 0, err is 0, every array byte and every shadow byte is 0, and no byte is flagged invalid.
- R2: While refresh_en is 1, a read returns rd_data 0xFF with rd_bad 0, a write is discarded, and err is set. Read results appear with rd_valid high in the cycle after acc_rd.
- R3: A write accepted while refresh_en and busy are both 0 is latched. A bus_stop pulse then raises busy in the next cycle. Busy stays high for exactly PROG_CYCLES cycles, after which the byte reads back as written.
- R4: While busy is 1, a read returns 0xFF, a write is discarded, and err is set.
- R5: Only one write is queued per stop condition. A further write arriving before the stop is discarded and sets err.
- R6: If supply_ok is 0 while busy is 1, busy clears in the next cycle and the array byte keeps its old value. That address then reads with rd_bad 1 until a later write to it completes.
- R7: While refresh_en is 1 and busy is 0, shadow byte k is loaded from array address k (k = 0..3) in rotation, so every byte is refreshed within 4 cycles. Shadow byte 0 drives four outputs: trickle_sel from bits 3:0, clk_sel from bits 5:4, therm_en from bit 6 and therm_period from bit 7. Bytes 1, 2 and 3 drive cfg_trim bits 7:0, 15:8 and 23:16.
- R8: While refresh_en is 0, the shadow outputs do not change, even when the control page is rewritten.
- R9: err stays 1 until a ctl_we with ctl_wdata bit 1 set. A ctl_we loads refresh_en from ctl_wdata bit 0.
- R10: A bus_stop pulse with no latched write leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Programming supply is adequate |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 0 refresh enable, bit 1 clear error |
| acc_rd | input | 1 | Array read request |
| acc_wr | input | 1 | Array write request |
| acc_addr | input | ADDR_W | Array byte address |
| acc_wdata | input | 8 | Write data |
| bus_stop | input | 1 | Bus transaction stop condition |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| rd_bad | output | 1 | Read byte was left invalid by an aborted write |
| refresh_en | output | 1 | Refresh-enable bit |
| busy | output | 1 | Programming in progress |
| err | output | 1 | Sticky interlock violation flag |
| trickle_sel | output | 4 | Trickle-charger resistor selects |
| clk_sel | output | 2 | Output clock select |
| therm_en | output | 1 | Thermometer enable |
| therm_period | output | 1 | Thermometer period select |
| cfg_trim | output | 24 | Compensation constants, bytes 1..3 |

## Verification
A programming counter that loaded the wrong value would show at once, because busy would be high for the wrong number of cycles. A stuck queued-write flag would turn up at the next stop condition: a spurious busy pulse would appear, or an expected one would be missing. A corrupted refresh pointer or gating signal would appear on the shadow-decoded outputs within four cycles of enabling refresh. If the gating is wrong while refresh is disabled, the shadow outputs would change after the control page is rewritten. A lost abort or a wrong invalid flag is visible on the first read of the affected address.

// File: rtl/nvm_access_guard.sv
module nvm_access_guard #(
  parameter int ADDR_W      = 4,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  input  logic              bus_stop,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_bad,
  output logic              refresh_en,
  output logic              busy,
  output logic              err,
  output logic [3:0]        trickle_sel,
  output logic [1:0]        clk_sel,
  output logic              therm_en,
  output logic              therm_period,
  output logic [23:0]       cfg_trim
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [7:0]        mem [DEPTH];
  logic [DEPTH-1:0]  bad;
  logic [31:0]       shadow;
  logic [1:0]        ptr;
  logic              pend;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]        p_data;
  logic [CNT_W-1:0]  cnt;

  wire locked   = refresh_en | busy;
  wire wr_ok    = acc_wr & ~locked & ~pend;
  wire wr_rej   = acc_wr & ~wr_ok;
  wire rd_rej   = acc_rd & locked;
  wire refresh  = refresh_en & ~busy;
  wire start    = bus_stop & pend & ~busy;
  wire abort    = busy & ~supply_ok;
  wire finish   = busy & supply_ok & (cnt == '0);

  assign trickle_sel  = shadow[3:0];
  assign clk_sel      = shadow[5:4];
  assign therm_en     = shadow[6];
  assign therm_period = shadow[7];
  assign cfg_trim     = shadow[31:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_en <= 1'b1;
      err        <= 1'b0;
    end else begin
      if (ctl_we) refresh_en <= ctl_wdata[0];
      if (wr_rej || rd_rej) err <= 1'b1;
      else if (ctl_we && ctl_wdata[1]) err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      p_addr <= '0;
      p_data <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
    end else begin
      if (wr_ok) begin
        pend   <= 1'b1;
        p_addr <= acc_addr;
        p_data <= acc_wdata;
      end
      if (start) begin
        pend <= 1'b0;
        busy <= 1'b1;
        cnt  <= CNT_W'(PROG_CYCLES - 1);
      end else if (abort || finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      bad <= '0;
    end else if (finish) begin
      mem[p_addr] <= p_data;
      bad[p_addr] <= 1'b0;
    end else if (abort) begin
      bad[p_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_bad   <= 1'b0;
    end else begin
      rd_valid <= acc_rd;
      if (rd_rej) begin
        rd_data <= 8'hFF;
        rd_bad  <= 1'b0;
      end else if (acc_rd) begin
        rd_data <= mem[acc_addr];
        rd_bad  <= bad[acc_addr];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      ptr    <= '0;
    end else if (refresh) begin
      shadow[ptr*8 +: 8] <= mem[{{(ADDR_W-2){1'b0}}, ptr}];
      ptr <= ptr + 1'b1;
    end
  end

  a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && pend && !busy) |=> busy);
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CNT_W'(PROG_CYCLES)));
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(bus_stop && pend)) |=> !busy);
  a_r2_reject_data: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && (refresh_en || busy)) |=> (rd_valid && rd_data == 8'hFF));
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !supply_ok) |=> !busy);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(ctl_we && ctl_wdata[1])) |=> err);
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_en || busy) |=> $stable(shadow));

endmodule

// File: tb/test_nvm_access_guard.sv
module test_nvm_access_guard;
  localparam int AW = 4;
  localparam int PC = 20;

  logic clk = 0, rst_n = 0;
  logic supply_ok = 1, ctl_we = 0, acc_rd = 0, acc_wr = 0, bus_stop = 0;
  logic [1:0] ctl_wdata = 0;
  logic [AW-1:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic rd_valid, rd_bad, refresh_en, busy, err, therm_en, therm_period;
  logic [7:0] rd_data;
  logic [3:0] trickle_sel;
  logic [1:0] clk_sel;
  logic [23:0] cfg_trim;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nvm_access_guard #(.ADDR_W(AW), .PROG_CYCLES(PC)) i_nvm_access_guard (
    .clk, .rst_n, .supply_ok, .ctl_we, .ctl_wdata, .acc_rd, .acc_wr, .acc_addr,
    .acc_wdata, .bus_stop, .rd_valid, .rd_data, .rd_bad, .refresh_en, .busy, .err,
    .trickle_sel, .clk_sel, .therm_en, .therm_period, .cfg_trim);

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(logic [1:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, int exp, int expbad, string tag);
    acc_rd = 1; acc_addr = a; tick(); acc_rd = 0;
    check({tag, " rd_valid"}, rd_valid, 1);
    check({tag, " rd_data"}, rd_data, exp);
    check({tag, " rd_bad"}, rd_bad, expbad);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    acc_wr = 1; acc_addr = a; acc_wdata = d; tick(); acc_wr = 0;
  endtask

  task automatic stop_pulse();
    bus_stop = 1; tick(); bus_stop = 0;
  endtask

  task automatic wait_idle();
    while (busy) tick();
  endtask

  task automatic t_reset();
    check("R1 refresh_en", refresh_en, 1);
    check("R1 busy", busy, 0);
    check("R1 err", err, 0);
    check("R1 cfg_trim", cfg_trim, 0);
    check("R1 trickle", trickle_sel, 0);
  endtask

  task automatic t_refresh_lock();
    rd(3, 8'hFF, 0, "R2 read while refresh");
    check("R2 err set", err, 1);
    wr(3, 8'h77); stop_pulse();
    check("R2 write ignored busy", busy, 0);
    tick(3);
    check("R9 err sticky", err, 1);
    ctl(2'b11);
    check("R9 err cleared", err, 0);
    check("R9 refresh kept", refresh_en, 1);
    ctl(2'b00);
    check("R9 refresh loaded", refresh_en, 0);
    rd(3, 0, 0, "R2 discarded write");
  endtask

  task automatic t_program();
    int n = 0;
    wr(5, 8'hA5);
    check("R3 no busy before stop", busy, 0);
    stop_pulse();
    while (busy && n < 1000) begin n++; tick(); end
    check("R3 busy length", n, PC);
    rd(5, 8'hA5, 0, "R3 readback");
    check("R3 no err", err, 0);
  endtask

  task automatic t_busy_lock();
    wr(6, 8'h3C); stop_pulse();
    check("R4 busy", busy, 1);
    rd(6, 8'hFF, 0, "R4 read while busy");
    wr(7, 8'h99);
    check("R4 err", err, 1);
    wait_idle();
    rd(6, 8'h3C, 0, "R4 first write done");
    rd(7, 0, 0, "R4 dropped write");
    ctl(2'b10);
  endtask

  task automatic t_queue();
    wr(8, 8'h22); wr(9, 8'h33);
    check("R5 err on second", err, 1);
    stop_pulse(); wait_idle();
    rd(8, 8'h22, 0, "R5 first kept");
    rd(9, 0, 0, "R5 second dropped");
    ctl(2'b10);
    stop_pulse();
    check("R10 stop without write", busy, 0);
    tick(2);
    check("R10 still idle", busy, 0);
  endtask

  task automatic t_abort();
    wr(10, 8'h5A); stop_pulse(); tick(3);
    supply_ok = 0; tick();
    check("R6 busy cleared", busy, 0);
    supply_ok = 1;
    rd(10, 0, 1, "R6 aborted byte");
    wr(10, 8'h5A); stop_pulse(); wait_idle();
    rd(10, 8'h5A, 0, "R6 rewritten byte");
  endtask

  task automatic t_shadow();
    wr(0, 8'hD6); stop_pulse(); wait_idle();
    wr(1, 8'h12); stop_pulse(); wait_idle();
    wr(2, 8'h34); stop_pulse(); wait_idle();
    wr(3, 8'h56); stop_pulse(); wait_idle();
    check("R8 shadow held while disabled", cfg_trim, 0);
    ctl(2'b01); tick(5);
    check("R7 trickle", trickle_sel, 4'h6);
    check("R7 clk_sel", clk_sel, 2'b01);
    check("R7 therm_en", therm_en, 1);
    check("R7 therm_period", therm_period, 1);
    check("R7 trim", cfg_trim, 24'h563412);
    ctl(2'b00);
    wr(0, 8'h00); stop_pulse(); wait_idle(); tick(5);
    check("R8 trickle held", trickle_sel, 4'h6);
    check("R8 therm held", therm_en, 1);
    ctl(2'b01); tick(5);
    check("R7 re-refresh", {therm_period, therm_en, clk_sel, trickle_sel}, 0);
  endtask

  initial begin
    tick(2); rst_n = 1; tick();
    t_reset();
    t_refresh_lock();
    t_program();
    t_busy_lock();
    t_queue();
    t_abort();
    t_shadow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule